// File: doc/BRIEF.md
# Interrupt Source PQ State Controller

This block keeps a two-bit state for each source in a bank of interrupt sources. Software and hardware reach it only through loads and stores on a memory-mapped window. Each source owns two adjacent pages. A store to the first page, the trigger page, fires the source. The second page, the management page, serves three purposes: a load there reads the state or forces it to a chosen value, and a store there ends the interrupt. Some loads therefore change state as a side effect. Every load returns the state as it stood before that load acted.

When an operation makes a source pending, the block raises a notify pulse that carries the source number, so that a routing stage further down can deliver it. The notify output uses a valid/ready handshake and holds at most one event. While an event is held and the next operation in flight could produce another, the block stops taking requests. The state array sits in a memory that can map onto block RAM. A sweep after reset sets every source to off, and back-to-back operations on one source are forwarded so that each one sees the result of the one before it.

Top module: `pqs_ctrl`

## Requirements
- R1: After a synchronous reset, req_ready stays low for exactly 2^SRC_W cycles, counted from the first cycle with reset low. During that time rsp_valid and notify_valid stay low. After it, every source reads state 01 (off).
- R2: The fields of req_addr are laid out as follows. The bits above bit PAGE_BITS hold the source index. Bit PAGE_BITS selects the page: 0 for the trigger page, 1 for the management page. The 4-bit op code sits in bits [PAGE_BITS-1:PAGE_BITS-4]. The bits below the op code are ignored. An operation on one source leaves every other source unchanged.
- R3: Every accepted load produces exactly one rsp_valid pulse, in order. rsp_pq carries the source's state before the load's own effect. With no back-pressure, the pulse comes two cycles after acceptance. Stores never produce a response.
- R4: A load from the management page with op code 0x0 returns the state and leaves it unchanged.
- R5: A load from the management page with op code 0x4 to 0x7 forces the state to the low two bits of the code (0x4 gives 00, 0x5 gives 01, 0x6 gives 10, 0x7 gives 11).
- R6: A store to the trigger page behaves according to the current state. From 00 (reset) it moves to 10 (pending) and emits one notify. From 10 it moves to 11 (queued) with no notify. State 11 stays 11 with no notify. State 01 (off) is ignored.
- R7: A store to the management page with op code 0x0 (end of interrupt) behaves according to the current state. From 10 it moves to 00. From 11 it moves to 10 and emits one notify. States 00 and 01 are unchanged.
- R8: Three kinds of access leave the state unchanged: loads from the trigger page, loads from the management page with any code other than 0x0 and 0x4 to 0x7, and stores to the management page with any code other than 0x0. The loads still return the state.
- R9: notify_valid and notify_src present each notify event once, in acceptance order. With notify_ready high, an event appears two cycles after acceptance. While notify_ready is low, notify_valid stays high and notify_src stays stable.
- R10: Suppose a notify is held and a trigger-page store or an end-of-interrupt store is waiting to complete. Then req_ready is low until the held notify is taken, and no request or event is lost.
- R11: Operations on the same source in consecutive cycles each see the state left by the one before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Request accepted this cycle when high |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | SRC_W+1+PAGE_BITS | Source index, page select, op code, ignored low bits |
| rsp_valid | output | 1 | Load response pulse |
| rsp_pq | output | 2 | State before the load |
| notify_valid | output | 1 | Notify event present |
| notify_ready | input | 1 | Downstream takes the notify event |
| notify_src | output | SRC_W | Source index of the notify event |

## Verification
The bench builds the block with SRC_W=3 and PAGE_BITS=6, which gives eight sources and a 10-bit address. With so few sources, the reset sweep is short enough to count cycle by cycle, every source can be read back, and random traffic often hits the same source in consecutive cycles, which exercises the forwarding path. The small page leaves two ignored low address bits, and the bench randomizes them alongside every op code, including unassigned ones. Phases with notify_ready randomly low exercise the stall and hold behaviour, and phases with it held high pin down the exact two-cycle latency.

// File: rtl/pqs_pkg.sv
package pqs_pkg;

  // Per-source state encoding
  localparam logic [1:0] PQ_RST  = 2'b00;
  localparam logic [1:0] PQ_OFF  = 2'b01;
  localparam logic [1:0] PQ_PEND = 2'b10;
  localparam logic [1:0] PQ_QUED = 2'b11;

  // Management page op codes
  localparam int         CODE_W   = 4;
  localparam logic [3:0] CODE_GET = 4'h0;  // load: read only
  localparam logic [3:0] CODE_EOI = 4'h0;  // store: end of interrupt
  localparam logic [1:0] SET_GRP  = 2'b01; // load: code 01xx forces xx

  typedef enum logic [2:0] {
    OP_NONE,
    OP_TRIG,
    OP_EOI,
    OP_GET,
    OP_SET
  } pqs_op_e;

  typedef struct packed {
    pqs_op_e    kind;
    logic [1:0] val;
  } pqs_cmd_t;

endpackage

// File: rtl/pqs_decode.sv
module pqs_decode
  import pqs_pkg::*;
#(
  parameter int SRC_W     = 6,
  parameter int PAGE_BITS = 12
) (
  input  logic                       write,
  input  logic [SRC_W+PAGE_BITS:0]   addr,
  output logic [SRC_W-1:0]           src,
  output pqs_cmd_t                   cmd
);

  logic [CODE_W-1:0] code;
  logic              mgmt;
  logic              unused_low_bits;

  // R2: source above the page bit, op code at the top of the page offset
  assign code            = addr[PAGE_BITS-1 -: CODE_W];
  assign mgmt            = addr[PAGE_BITS];
  assign src             = addr[SRC_W+PAGE_BITS : PAGE_BITS+1];
  assign unused_low_bits = ^addr[PAGE_BITS-CODE_W-1:0];

  always_comb begin
    cmd.kind = OP_NONE;
    cmd.val  = code[1:0];
    if (!mgmt) begin
      // R6 / R8: trigger page, any store fires, a load only reads
      cmd.kind = write ? OP_TRIG : OP_GET;
    end else if (write) begin
      // R7 / R8
      cmd.kind = (code == CODE_EOI) ? OP_EOI : OP_NONE;
    end else if (code[3:2] == SET_GRP) begin
      // R5
      cmd.kind = OP_SET;
    end else begin
      // R4 / R8: code GET and unassigned codes read without change
      cmd.kind = OP_GET;
    end
  end

endmodule

// File: rtl/pqs_next.sv
module pqs_next
  import pqs_pkg::*;
(
  input  pqs_cmd_t   cmd,
  input  logic [1:0] cur,
  output logic [1:0] nxt,
  output logic       notify,
  output logic       is_load
);

  always_comb begin
    nxt     = cur;
    notify  = 1'b0;
    is_load = 1'b0;
    unique case (cmd.kind)
      OP_TRIG: begin
        if (cur == PQ_RST) begin
          nxt    = PQ_PEND;
          notify = 1'b1;
        end else if (cur == PQ_PEND) begin
          nxt = PQ_QUED;
        end
      end
      OP_EOI: begin
        if (cur == PQ_PEND) begin
          nxt = PQ_RST;
        end else if (cur == PQ_QUED) begin
          nxt    = PQ_PEND;
          notify = 1'b1;
        end
      end
      OP_GET: is_load = 1'b1;
      OP_SET: begin
        is_load = 1'b1;
        nxt     = cmd.val;
      end
      default: ;
    endcase
  end

  // R6 R7: every event leaves the source pending
  always_comb begin
    if (notify) begin
      notify_to_pending_chk: assert (nxt == PQ_PEND);
    end
  end

endmodule

// File: rtl/pqs_ram.sv
module pqs_ram #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 2
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/pqs_ctrl.sv
module pqs_ctrl
  import pqs_pkg::*;
#(
  parameter int SRC_W     = 6,
  parameter int PAGE_BITS = 12
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic                       req_write,
  input  logic [SRC_W+PAGE_BITS:0]   req_addr,
  output logic                       rsp_valid,
  output logic [1:0]                 rsp_pq,
  output logic                       notify_valid,
  input  logic                       notify_ready,
  output logic [SRC_W-1:0]           notify_src
);

  localparam int NSRC = 1 << SRC_W;
  localparam logic [SRC_W-1:0] LAST_SRC = SRC_W'(NSRC - 1);

  // reset sweep
  logic             swept;
  logic [SRC_W-1:0] sweep_cnt;

  // decode
  logic [SRC_W-1:0] d_src;
  pqs_cmd_t         d_cmd;

  // stage 1
  logic             s1_valid;
  logic [SRC_W-1:0] s1_src;
  pqs_cmd_t         s1_cmd;

  // memory ports
  logic             ram_we;
  logic [SRC_W-1:0] ram_waddr;
  logic [1:0]       ram_wdata;
  logic [SRC_W-1:0] ram_raddr;
  logic [1:0]       ram_rdata;

  // bypass of the latest write
  logic             byp_valid;
  logic [SRC_W-1:0] byp_src;
  logic [1:0]       byp_pq;

  logic [1:0]       cur_pq;
  logic [1:0]       nxt_pq;
  logic             nxt_notify;
  logic             nxt_load;
  logic             may_notify;
  logic             stall;
  logic             fire;
  logic             accept;

  pqs_decode #(
    .SRC_W    (SRC_W),
    .PAGE_BITS(PAGE_BITS)
  ) u_decode (
    .write(req_write),
    .addr (req_addr),
    .src  (d_src),
    .cmd  (d_cmd)
  );

  pqs_ram #(
    .ADDR_W(SRC_W),
    .DATA_W(2)
  ) u_ram (
    .clk  (clk),
    .we   (ram_we),
    .waddr(ram_waddr),
    .wdata(ram_wdata),
    .raddr(ram_raddr),
    .rdata(ram_rdata)
  );

  pqs_next u_next (
    .cmd    (s1_cmd),
    .cur    (cur_pq),
    .nxt    (nxt_pq),
    .notify (nxt_notify),
    .is_load(nxt_load)
  );

  // R11: the latest write wins over the memory read
  assign cur_pq = (byp_valid && (byp_src == s1_src)) ? byp_pq : ram_rdata;

  // R10: hold stage 1 if it may need the notify slot while it is occupied
  assign may_notify = s1_cmd.kind inside {OP_TRIG, OP_EOI};
  assign stall      = s1_valid && may_notify && notify_valid && !notify_ready;
  assign fire       = s1_valid && !stall;
  assign req_ready  = swept && !stall;
  assign accept     = req_valid && req_ready;

  assign ram_raddr  = stall ? s1_src : d_src;
  assign ram_we     = !swept || fire;
  assign ram_waddr  = swept ? s1_src : sweep_cnt;
  assign ram_wdata  = swept ? nxt_pq : PQ_OFF;

  // R1: one entry per cycle set to off
  always_ff @(posedge clk) begin
    if (rst) begin
      sweep_cnt <= '0;
      swept     <= 1'b0;
    end else if (!swept) begin
      sweep_cnt <= sweep_cnt + 1'b1;
      if (sweep_cnt == LAST_SRC) begin
        swept <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_src   <= '0;
      s1_cmd   <= '{kind: OP_NONE, val: 2'b00};
    end else if (!stall) begin
      s1_valid <= accept && (d_cmd.kind != OP_NONE);
      s1_src   <= d_src;
      s1_cmd   <= d_cmd;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      byp_valid <= 1'b0;
      byp_src   <= '0;
      byp_pq    <= PQ_OFF;
    end else if (fire) begin
      byp_valid <= 1'b1;
      byp_src   <= s1_src;
      byp_pq    <= nxt_pq;
    end
  end

  // R3
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_pq    <= PQ_RST;
    end else begin
      rsp_valid <= fire && nxt_load;
      if (fire) begin
        rsp_pq <= cur_pq;
      end
    end
  end

  // R9
  always_ff @(posedge clk) begin
    if (rst) begin
      notify_valid <= 1'b0;
      notify_src   <= '0;
    end else begin
      if (notify_valid && notify_ready) begin
        notify_valid <= 1'b0;
      end
      if (fire && nxt_notify) begin
        notify_valid <= 1'b1;
        notify_src   <= s1_src;
      end
    end
  end

  // R9
  notify_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (notify_valid && !notify_ready) |=> (notify_valid && $stable(notify_src)));

  // R1
  sweep_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !swept |-> (!rsp_valid && !notify_valid && !s1_valid));

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    stall |=> (s1_valid && $stable(s1_src) && $stable(s1_cmd)));

  // R3
  rsp_origin_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(s1_valid));

endmodule

// File: tb/tb_pqs_ctrl.sv
`timescale 1ns/1ps
module tb_pqs_ctrl;

  localparam int SW = 3;
  localparam int PB = 6;
  localparam int AW = SW + 1 + PB;
  localparam int NS = 1 << SW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic          rsp_valid;
  logic [1:0]    rsp_pq;
  logic          notify_valid;
  logic          notify_ready = 1'b1;
  logic [SW-1:0] notify_src;

  pqs_ctrl #(.SRC_W(SW), .PAGE_BITS(PB)) dut (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_pq(rsp_pq),
    .notify_valid(notify_valid), .notify_ready(notify_ready),
    .notify_src(notify_src)
  );

  always #4 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit strict = 1'b1;
  bit nr_cur = 1'b1;
  bit last_acc = 1'b0;
  int last_rsp = -1;
  int nseen = 0;
  bit held_prev = 1'b0;
  int held_src = 0;

  int pq_m [NS];
  int    rq_pq[$];
  int    rq_due[$];
  string rq_tag[$];
  int    nq_src[$];
  int    nq_due[$];
  string nq_tag[$];

  task automatic chk(string tag, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  // R2: {source, page, code, ignored low bits}
  function automatic logic [AW-1:0] mk(int src, bit mg, int code, int low = 0);
    logic [SW-1:0]   s = src[SW-1:0];
    logic [3:0]      c = code[3:0];
    logic [PB-5:0]   l = low[PB-5:0];
    return {s, mg, c, l};
  endfunction

  task automatic apply(bit w, logic [AW-1:0] a);
    int src  = int'(a[AW-1:PB+1]);
    bit mg   = a[PB];
    int code = int'(a[PB-1 -: 4]);
    int cur  = pq_m[src];
    int nw   = cur;
    if (!w) begin
      rq_pq.push_back(cur);
      rq_due.push_back(cyc + 2);
      if (!mg) rq_tag.push_back("R8");
      else if (code == 0) rq_tag.push_back("R4");
      else if (code >= 4 && code <= 7) rq_tag.push_back("R5");
      else rq_tag.push_back("R8");
    end
    if (!mg && w) begin
      if (cur == 0) begin
        nw = 2;
        nq_src.push_back(src); nq_due.push_back(cyc + 2); nq_tag.push_back("R6");
      end else if (cur == 2) nw = 3;
    end else if (mg && w && code == 0) begin
      if (cur == 2) nw = 0;
      else if (cur == 3) begin
        nw = 2;
        nq_src.push_back(src); nq_due.push_back(cyc + 2); nq_tag.push_back("R7");
      end
    end else if (mg && !w && code >= 4 && code <= 7) begin
      nw = code & 3;
    end
    pq_m[src] = nw;
  endtask

  task automatic check_outputs();
    if (rsp_valid) begin
      if (rq_pq.size() == 0) begin
        checks++; fails++;
        $display("FAIL R3 unexpected response: actual %0d expected none", rsp_pq);
      end else begin
        int p = rq_pq.pop_front();
        int d = rq_due.pop_front();
        string t = rq_tag.pop_front();
        chk(t, int'(rsp_pq), p, "load data");
        if (strict) chk("R3", cyc, d, "response cycle");
        last_rsp = int'(rsp_pq);
      end
    end else if (strict && rq_due.size() > 0 && rq_due[0] <= cyc) begin
      chk("R3", 0, 1, "response missing");
      void'(rq_pq.pop_front()); void'(rq_due.pop_front()); void'(rq_tag.pop_front());
    end
    if (held_prev) begin
      chk("R9", int'(notify_valid), 1, "held notify valid");
      chk("R9", int'(notify_src), held_src, "held notify source");
    end
    if (strict && !notify_valid && nq_due.size() > 0 && nq_due[0] <= cyc) begin
      chk("R9", 0, 1, "notify missing");
      void'(nq_src.pop_front()); void'(nq_due.pop_front()); void'(nq_tag.pop_front());
    end
  endtask

  task automatic step(bit v, bit w, logic [AW-1:0] a, bit nr);
    check_outputs();
    req_valid    = v;
    req_write    = w;
    req_addr     = a;
    notify_ready = nr;
    #1;
    if (notify_valid && notify_ready) begin
      nseen++;
      if (nq_src.size() == 0) begin
        checks++; fails++;
        $display("FAIL R9 unexpected notify: actual %0d expected none", notify_src);
      end else begin
        int s = nq_src.pop_front();
        int d = nq_due.pop_front();
        string t = nq_tag.pop_front();
        chk(t, int'(notify_src), s, "notify source");
        if (strict) chk("R9", cyc, d, "notify cycle");
      end
    end
    held_prev = notify_valid && !notify_ready;
    held_src  = int'(notify_src);
    last_acc  = v && req_ready;
    if (last_acc) apply(w, a);
    @(negedge clk);
    cyc++;
  endtask

  task automatic op(bit w, logic [AW-1:0] a);
    do step(1'b1, w, a, nr_cur); while (!last_acc);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, '0, nr_cur);
  endtask

  task automatic get_lit(int src, int exp, string tag);
    op(1'b0, mk(src, 1'b1, 0));
    idle(3);
    chk(tag, last_rsp, exp, "state read back");
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual 200000 cycles expected completion before");
    summary();
    $finish;
  end

  initial begin
    int n;
    int n0;
    for (int i = 0; i < NS; i++) pq_m[i] = 1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    // R1: sweep length and idle outputs
    chk("R1", int'(rsp_valid), 0, "rsp_valid after reset");
    chk("R1", int'(notify_valid), 0, "notify_valid after reset");
    n = 0;
    while (!req_ready && n < 1000) begin
      @(negedge clk);
      cyc++;
      n++;
    end
    chk("R1", n, NS, "cycles with req_ready low");
    for (int s = 0; s < NS; s++) get_lit(s, 1, "R1");

    // R6: trigger on an off source is ignored
    n0 = nseen;
    op(1'b1, mk(2, 1'b0, 0));
    idle(3);
    chk("R6", nseen - n0, 0, "notify from off source");
    get_lit(2, 1, "R6");
    // R5: force 00 returns previous state
    op(1'b0, mk(2, 1'b1, 4));
    idle(3);
    chk("R5", last_rsp, 1, "previous state from force");
    get_lit(2, 0, "R5");
    // R6: 00 -> 10 with one notify
    n0 = nseen;
    op(1'b1, mk(2, 1'b0, 0, 3));
    idle(3);
    chk("R6", nseen - n0, 1, "notify count from reset state");
    get_lit(2, 2, "R6");
    // R6: 10 -> 11 and 11 -> 11, no notify
    n0 = nseen;
    op(1'b1, mk(2, 1'b0, 0));
    idle(3);
    get_lit(2, 3, "R6");
    op(1'b1, mk(2, 1'b0, 0));
    idle(3);
    get_lit(2, 3, "R6");
    chk("R6", nseen - n0, 0, "notify count while pending");
    // R4: a second read sees the same value
    get_lit(2, 3, "R4");
    // R7: 11 -> 10 with notify, 10 -> 00, 00 stays
    n0 = nseen;
    op(1'b1, mk(2, 1'b1, 0));
    idle(3);
    chk("R7", nseen - n0, 1, "notify count on end from queued");
    get_lit(2, 2, "R7");
    op(1'b1, mk(2, 1'b1, 0));
    idle(3);
    get_lit(2, 0, "R7");
    op(1'b1, mk(2, 1'b1, 0));
    idle(3);
    get_lit(2, 0, "R7");
    chk("R7", nseen - n0, 1, "notify count total");
    // R8: reads and stores that do nothing
    op(1'b0, mk(2, 1'b0, 6));
    idle(3);
    chk("R8", last_rsp, 0, "trigger page load data");
    op(1'b1, mk(2, 1'b1, 5));
    op(1'b1, mk(2, 1'b1, 7));
    idle(3);
    get_lit(2, 0, "R8");
    op(1'b0, mk(2, 1'b1, 9));
    idle(3);
    chk("R8", last_rsp, 0, "unassigned code load data");
    get_lit(2, 0, "R8");
    // R5: all forced values
    op(1'b0, mk(2, 1'b1, 7));
    idle(3);
    get_lit(2, 3, "R5");
    op(1'b0, mk(2, 1'b1, 6));
    idle(3);
    get_lit(2, 2, "R5");
    op(1'b0, mk(2, 1'b1, 5));
    idle(3);
    get_lit(2, 1, "R5");
    // R2: neighbours untouched, low offset bits ignored
    get_lit(3, 1, "R2");
    get_lit(1, 1, "R2");
    op(1'b0, mk(3, 1'b1, 0, 3));
    idle(3);
    chk("R2", last_rsp, 1, "load with low bits set");

    // R11: back-to-back on one source
    op(1'b0, mk(5, 1'b1, 4));
    op(1'b1, mk(5, 1'b0, 0));
    op(1'b1, mk(5, 1'b0, 0));
    op(1'b0, mk(5, 1'b1, 0));
    idle(3);
    chk("R11", last_rsp, 3, "state after back-to-back");

    // R10: back-pressure
    strict = 1'b0;
    nr_cur = 1'b0;
    op(1'b0, mk(6, 1'b1, 4));
    op(1'b0, mk(7, 1'b1, 4));
    n0 = nseen;
    op(1'b1, mk(6, 1'b0, 0));
    op(1'b1, mk(7, 1'b0, 0));
    idle(2);
    chk("R10", int'(req_ready), 0, "ready while notify held");
    chk("R10", int'(notify_valid), 1, "held notify present");
    chk("R10", int'(notify_src), 6, "held notify source");
    idle(4);
    nr_cur = 1'b1;
    idle(8);
    chk("R10", nseen - n0, 2, "notify count after release");
    get_lit(7, 2, "R10");

    // random traffic with back-pressure
    for (int i = 0; i < 4000; i++) begin
      int src  = $urandom_range(NS - 1);
      int sel  = $urandom_range(9);
      int code = (sel < 4) ? 0 : (sel < 8) ? (sel) : $urandom_range(15);
      step(($urandom_range(9) < 7), $urandom_range(1) == 1,
           mk(src, $urandom_range(1) == 1, code, $urandom_range(3)),
           ($urandom_range(3) != 0));
    end
    nr_cur = 1'b1;
    idle(10);
    strict = 1'b1;
    // random traffic with exact timing
    for (int i = 0; i < 2000; i++) begin
      int src  = $urandom_range(NS - 1);
      int sel  = $urandom_range(9);
      int code = (sel < 4) ? 0 : (sel < 8) ? (sel) : $urandom_range(15);
      step(($urandom_range(9) < 8), $urandom_range(1) == 1,
           mk(src, $urandom_range(1) == 1, code, $urandom_range(3)), 1'b1);
    end
    idle(6);
    for (int s = 0; s < NS; s++) begin
      op(1'b0, mk(s, 1'b1, 0));
    end
    idle(4);
    chk("R3", rq_pq.size(), 0, "responses outstanding at end");
    chk("R9", nq_src.size(), 0, "notifies outstanding at end");
    summary();
    $finish;
  end

endmodule